// File: doc/BRIEF.md
# Shared Bus Ownership Lock

This block decides which of two masters may drive a shared two-wire management bus controller. One master is the host, which reaches the block through a small byte-wide register window. The other is an on-chip microcontroller, which has dedicated request and release strobes. At any moment the bus belongs to the host, to the microcontroller, or to nobody. The block reports the owner on two flags.

The host controls the lock through one control register. To ask for the bus, it writes a 1 into the request bit. It then reads the same bit back to learn whether it won. To give the bus up, it writes a 1 into a separate release bit; that bit always reads back as 0.

A request that loses, either to a current owner or to a same-cycle request from the microcontroller, is discarded. The host must issue it again later. The grant is registered at the clock edge that takes the write, so a read one cycle later already shows the result. The remaining bits of the control register are ordinary storage.

Top module: `smb_share_lock`

## Requirements
- R1: After reset, neither side owns the lock and the control register (address 8) reads 0x00.
- R2: When the lock is free, a host write to address 8 has bit 4 set and bit 5 clear, and the microcontroller is not requesting in that cycle, the host owns the lock from the next cycle. Bit 4 of address 8 then reads 1.
- R3: The host flag and the microcontroller flag are never both 1.
- R4: A host request written while the microcontroller owns the lock is discarded. Bit 4 reads 0, and after the microcontroller releases, the host still does not own the lock until it writes the request again.
- R5: If the lock is free and the host request write and the microcontroller request arrive in the same cycle, the microcontroller owns the lock on the next cycle.
- R6: A host write to address 8 with bit 5 set frees a lock held by the host on the next cycle. Bit 5 always reads 0. A write with both bit 4 and bit 5 set never grants the lock to the host.
- R7: A microcontroller request pulse grants it a free lock on the next cycle, and its release pulse frees it. A microcontroller request while the host owns the lock is discarded: it is not granted after the host releases.
- R8: Bits 7:6 and 3:0 of address 8 read back the last value written there. Any other address reads 0x00, and writes to other addresses change nothing at address 8.
- R9: A host release write while the microcontroller owns the lock has no effect on ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_addr | input | 4 | Host register address, for both read and write |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from h_addr |
| ec_req | input | 1 | Microcontroller request pulse |
| ec_rel | input | 1 | Microcontroller release pulse |
| own_host | output | 1 | Host holds the lock |
| own_ec | output | 1 | Microcontroller holds the lock |

## Verification
The hardest situations to reach are the ones that depend on timing between the two masters. The first is a same-cycle collision between a host request write and a microcontroller request. The second is a discarded request that might wrongly survive a later release. The bench reaches the collision by driving the write strobe and the request pulse from a single task call, so both sit in the same clock cycle. For the discarded-request case, it lets the lock return to free between the losing request and the next check, so a queued request would show up as a grant.

// File: rtl/smb_share_lock.sv
module smb_share_lock #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd8,
  parameter int REQ_BIT = 4,
  parameter int REL_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              ec_req,
  input  logic              ec_rel,
  output logic              own_host,
  output logic              own_ec
);
  localparam logic [DATA_W-1:0] LOCK_BITS =
    (DATA_W'(1) << REQ_BIT) | (DATA_W'(1) << REL_BIT);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~LOCK_BITS;

  logic              host_q, ec_q;
  logic [DATA_W-1:0] store_q;

  wire ctrl_wr = h_wr && (h_addr == CTRL_ADDR);
  wire h_rel   = ctrl_wr && h_wdata[REL_BIT];
  wire h_req   = ctrl_wr && h_wdata[REQ_BIT] && !h_wdata[REL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q <= 1'b0;
      ec_q   <= 1'b0;
    end else if (ec_q) begin
      if (ec_rel) ec_q <= 1'b0;
    end else if (host_q) begin
      if (h_rel) host_q <= 1'b0;
    end else if (ec_req) begin
      ec_q <= 1'b1;
    end else if (h_req) begin
      host_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       store_q <= '0;
    else if (ctrl_wr) store_q <= h_wdata & KEEP_MASK;
  end

  assign h_rdata  = (h_addr == CTRL_ADDR) ? (store_q | (DATA_W'(host_q) << REQ_BIT)) : '0;
  assign own_host = host_q;
  assign own_ec   = ec_q;
endmodule

module smb_share_lock_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd8,
  parameter int REQ_BIT = 4,
  parameter int REL_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_wr,
  input logic [ADDR_W-1:0] h_addr,
  input logic [DATA_W-1:0] h_wdata,
  input logic [DATA_W-1:0] h_rdata,
  input logic              ec_req,
  input logic              ec_rel,
  input logic              own_host,
  input logic              own_ec
);
  wire wr_ctrl  = h_wr && (h_addr == CTRL_ADDR);
  wire host_ask = wr_ctrl && h_wdata[REQ_BIT] && !h_wdata[REL_BIT];
  wire is_free  = !own_host && !own_ec;

  assert_one_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(own_host && own_ec));

  assert_host_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_free && host_ask && !ec_req |=> own_host);

  assert_drop_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
    own_ec && host_ask |=> !own_host);

  assert_ec_wins_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_free && host_ask && ec_req |=> own_ec && !own_host);

  assert_host_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    own_host && wr_ctrl && h_wdata[REL_BIT] |=> !own_host);

  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_addr == CTRL_ADDR) |-> (h_rdata[REQ_BIT] == own_host) && !h_rdata[REL_BIT]);

  assert_ec_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_free && ec_req |=> own_ec);

  assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_addr != CTRL_ADDR) |-> (h_rdata == '0));
endmodule

bind smb_share_lock smb_share_lock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
  .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)
) u_chk (.*);

// File: tb/sim_smb_share_lock.sv
`timescale 1ns/1ps
module sim_smb_share_lock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_wr = 1'b0;
  logic [3:0] h_addr = 4'd8;
  logic [7:0] h_wdata = 8'h00;
  logic [7:0] h_rdata;
  logic       ec_req = 1'b0;
  logic       ec_rel = 1'b0;
  logic       own_host, own_ec;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  smb_share_lock u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [3:0] a, input logic [7:0] d,
                      input logic rq, input logic rl);
    @(negedge clk);
    h_wr = wr; h_addr = a; h_wdata = d; ec_req = rq; ec_rel = rl;
    @(negedge clk);
    h_wr = 1'b0; h_addr = 4'd8; ec_req = 1'b0; ec_rel = 1'b0;
    #0.5;
  endtask

  function automatic logic [7:0] rd(input logic [3:0] a);
    return (a == h_addr) ? h_rdata : 8'hxx;
  endfunction

  task automatic read_at(input logic [3:0] a, output logic [7:0] v);
    h_addr = a; #0.5; v = h_rdata; h_addr = 4'd8;
  endtask

  task automatic t_reset;
    check("R1 own_host", own_host, 0);
    check("R1 own_ec", own_ec, 0);
    check("R1 rdata", h_rdata, 8'h00);
  endtask

  task automatic t_host_cycle;
    step(1, 8, 8'h10, 0, 0);
    check("R2 own_host", own_host, 1);
    check("R2 bit4", h_rdata[4], 1);
    step(1, 8, 8'h20, 0, 0);
    check("R6 freed", own_host, 0);
    check("R6 readback", h_rdata, 8'h00);
  endtask

  task automatic t_tie;
    step(1, 8, 8'h10, 1, 0);
    check("R5 own_ec", own_ec, 1);
    check("R5 own_host", own_host, 0);
    check("R3 bit4", h_rdata[4], 0);
    step(0, 8, 8'h00, 0, 1);
    check("R7 ec release", own_ec, 0);
  endtask

  task automatic t_drop;
    step(0, 8, 8'h00, 1, 0);
    check("R7 ec grant", own_ec, 1);
    step(1, 8, 8'h10, 0, 0);
    check("R4 bit4 while ec", h_rdata[4], 0);
    step(1, 8, 8'h20, 0, 0);
    check("R9 ec kept", own_ec, 1);
    step(0, 8, 8'h00, 0, 1);
    check("R4 no queued grant", own_host, 0);
    check("R4 free", own_ec, 0);
    step(1, 8, 8'h10, 0, 0);
    check("R4 reissue", own_host, 1);
  endtask

  task automatic t_ec_ignored;
    step(0, 8, 8'h00, 1, 0);
    check("R7 ec ignored", own_ec, 0);
    check("R3 host kept", own_host, 1);
    step(1, 8, 8'h20, 0, 0);
    check("R7 not queued ec", own_ec, 0);
    check("R7 host freed", own_host, 0);
  endtask

  task automatic t_both_bits;
    step(1, 8, 8'h30, 0, 0);
    check("R6 both bits no grant", own_host, 0);
    check("R6 both bits read", h_rdata, 8'h00);
  endtask

  task automatic t_storage;
    logic [7:0] v;
    step(1, 8, 8'hCF, 0, 0);
    check("R8 store", h_rdata, 8'hCF);
    check("R8 no grant", own_host, 0);
    step(1, 8, 8'hDF, 0, 0);
    check("R8 store+grant", h_rdata, 8'hDF);
    step(1, 3, 8'h00, 0, 0);
    check("R8 other write", h_rdata, 8'hDF);
    read_at(3, v);
    check("R8 other read", v, 8'h00);
    step(1, 8, 8'hEF, 0, 0);
    check("R8 release read", h_rdata, 8'hCF);
    check("R6 release", own_host, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    t_reset;
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    t_reset;
    t_host_cycle;
    t_tie;
    t_drop;
    t_ec_ignored;
    t_both_bits;
    t_storage;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule